// File: doc/BRIEF.md
# Audio Control Packet Capture

This block watches a stream of 10-bit video words for ancillary packets that carry audio control information for one selected audio group. A packet is framed by the three-word component flag (0x000, 0x3FF, 0x3FF) and is followed by an identifier, a block number, a word count, the user words and a checksum word. When a packet for the active group is received in full, the low bytes of its first four user words are copied into four 8-bit parameter registers. The block does not interpret these bytes.

A separate status bit tells whether such a packet arrived on a designated video line during the last field. The line designation is supplied as an input level, `line_desig`, by logic outside the block. The status bit is recomputed once per field at the `field_start` strobe. Packets found on lines that are not designated still refresh the parameter registers, but they do not raise the status bit.

The word input has a valid/ready pair. `in_ready` is held high at all times, so the block never applies back-pressure. A word is taken in every cycle in which `in_valid` is high, and idle cycles between words are allowed anywhere in a packet.

Top module: `acp_capture`

## Requirements
- R1: `in_ready` is always 1. A word is consumed exactly in the cycles where `in_valid` is 1, and cycles with `in_valid` low do not disturb packet reception.
- R2: A packet is recognised only in this form: words 0x000, 0x3FF, 0x3FF, then an identifier word whose low byte is 0xEF, 0xEE, 0xED or 0xEC for groups 1, 2, 3 or 4 respectively, then a block-number word, a count word (low byte = count), that many user words, and one checksum word.
- R3: After a recognised packet's checksum word is accepted, the next clock edge loads `params_o[8k+7:8k]` with the low byte of user word k, for k = 0 to 3.
- R4: A packet whose count is below 4 changes no parameter register and no status.
- R5: A packet is abandoned when 0x000 or 0x3FF appears after the flag and before its checksum word has been accepted. The parameter registers keep their previous values.
- R6: `group_sel` is sampled at each `field_start`. Values 1 to 4 select that group, and any other value leaves the selection unchanged. After reset, group 1 is selected.
- R7: At each `field_start` edge, `ctrl_present` is loaded with 1 if and only if a recognised packet's checksum word was accepted during the closing field with `line_desig` high. A checksum word accepted in the same cycle as `field_start` counts toward the closing field. `ctrl_present` changes at no other time.
- R8: A recognised packet whose checksum word arrives with `line_desig` low still updates the parameter registers but does not set `ctrl_present`.
- R9: A packet whose identifier does not match the selected group has no effect on any output.
- R10: Reset clears `ctrl_present` and all parameter registers to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Word on `in_word` is valid this cycle |
| in_ready | output | 1 | Always 1; the block never back-pressures |
| in_word | input | 10 | Video/ancillary word |
| line_desig | input | 1 | Current line is a designated line |
| field_start | input | 1 | One-cycle strobe at the start of a field |
| group_sel | input | 4 | Requested audio group (1 to 4) |
| ctrl_present | output | 1 | Matching packet seen on a designated line in the last field |
| params_o | output | 32 | Four captured parameter bytes, byte k in bits 8k+7:8k |

## Verification
The checksum word that completes a packet and the `field_start` strobe can fall in the same cycle. The packet must then be counted toward the field that is closing. The bench provokes this by raising `field_start` together with the checksum word on a designated line. It then expects `ctrl_present` to read 1 after that edge, with the new parameters already loaded, and expects a following empty field to clear the bit.

// File: rtl/acp_pkg.sv
package acp_pkg;
  localparam int WORD_W = 10;

  typedef enum logic [2:0] {
    PS_IDLE = 3'd0,
    PS_DID  = 3'd1,
    PS_DBN  = 3'd2,
    PS_DC   = 3'd3,
    PS_UDW  = 3'd4,
    PS_CS   = 3'd5
  } pstate_t;

  // Control packet identifier for group g (1..4): 0xEF down to 0xEC.
  function automatic logic [7:0] ctrl_id(input logic [2:0] g);
    return 8'hF0 - {5'd0, g};
  endfunction

  // Words reserved for the ancillary flag, illegal inside a payload.
  function automatic logic is_flag_word(input logic [WORD_W-1:0] w);
    return (w == '0) || (w == '1);
  endfunction
endpackage

// File: rtl/acp_flag_detect.sv
module acp_flag_detect
  import acp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  output logic              flag_hit
);
  logic [WORD_W-1:0] prev1_q, prev2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev1_q <= '1;
      prev2_q <= '1;
    end else if (in_valid) begin
      prev1_q <= in_word;
      prev2_q <= prev1_q;
    end
  end

  // Third word of 0x000, 0x3FF, 0x3FF arrives now.
  assign flag_hit = in_valid && (in_word == '1) && (prev1_q == '1) && (prev2_q == '0);
endmodule

// File: rtl/acp_pkt_parser.sv
module acp_pkt_parser
  import acp_pkg::*;
#(
  parameter int NUM_PARAMS = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [WORD_W-1:0]       in_word,
  input  logic                    flag_hit,
  input  logic [7:0]              want_id,
  output logic                    commit,
  output logic [7:0]              dc_q,
  output logic [NUM_PARAMS*8-1:0] shadow_o
);
  localparam int         IDX_W = (NUM_PARAMS > 1) ? $clog2(NUM_PARAMS) : 1;
  localparam logic [7:0] NP8   = 8'(NUM_PARAMS);

  pstate_t    state_q;
  logic [7:0] cnt_q;
  logic [7:0] shadow_q [NUM_PARAMS];
  logic [7:0] wbyte;
  logic       rsv;

  assign wbyte = in_word[7:0];
  assign rsv   = is_flag_word(in_word);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PS_IDLE;
      cnt_q   <= '0;
      dc_q    <= '0;
      for (int k = 0; k < NUM_PARAMS; k++) shadow_q[k] <= '0;
    end else if (in_valid) begin
      if (flag_hit) begin
        state_q <= PS_DID;
      end else if (state_q != PS_IDLE && rsv) begin
        state_q <= PS_IDLE;
      end else begin
        case (state_q)
          PS_DID: state_q <= (wbyte == want_id) ? PS_DBN : PS_IDLE;
          PS_DBN: state_q <= PS_DC;
          PS_DC: begin
            dc_q    <= wbyte;
            cnt_q   <= '0;
            state_q <= (wbyte >= NP8) ? PS_UDW : PS_IDLE;
          end
          PS_UDW: begin
            if (cnt_q < NP8) shadow_q[cnt_q[IDX_W-1:0]] <= wbyte;
            if (cnt_q == 8'(dc_q - 8'd1)) state_q <= PS_CS;
            else cnt_q <= cnt_q + 8'd1;
          end
          PS_CS:   state_q <= PS_IDLE;
          default: state_q <= PS_IDLE;
        endcase
      end
    end
  end

  assign commit = in_valid && (state_q == PS_CS) && !rsv;

  for (genvar k = 0; k < NUM_PARAMS; k++) begin : g_flat
    assign shadow_o[k*8 +: 8] = shadow_q[k];
  end
endmodule

// File: rtl/acp_param_bank.sv
module acp_param_bank #(
  parameter int NUM_PARAMS = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic [NUM_PARAMS*8-1:0] shadow_i,
  output logic [NUM_PARAMS*8-1:0] params_o
);
  for (genvar k = 0; k < NUM_PARAMS; k++) begin : g_reg
    logic [7:0] val_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    val_q <= '0;
      else if (load) val_q <= shadow_i[k*8 +: 8];
    end
    assign params_o[k*8 +: 8] = val_q;
  end
endmodule

// File: rtl/acp_field_status.sv
module acp_field_status
  import acp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       field_start,
  input  logic [3:0] group_sel,
  input  logic       commit,
  input  logic       line_desig,
  output logic [2:0] grp_q,
  output logic [7:0] want_id,
  output logic       seen_q,
  output logic       ctrl_present
);
  logic hit_now;
  logic sel_ok;

  assign hit_now = commit && line_desig;
  assign sel_ok  = (group_sel >= 4'd1) && (group_sel <= 4'd4);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp_q        <= 3'd1;
      seen_q       <= 1'b0;
      ctrl_present <= 1'b0;
    end else if (field_start) begin
      if (sel_ok) grp_q <= group_sel[2:0];
      ctrl_present <= seen_q || hit_now;
      seen_q       <= 1'b0;
    end else if (hit_now) begin
      seen_q <= 1'b1;
    end
  end

  assign want_id = ctrl_id(grp_q);
endmodule

// File: rtl/acp_capture.sv
module acp_capture
  import acp_pkg::*;
#(
  parameter int NUM_PARAMS = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [9:0]              in_word,
  input  logic                    line_desig,
  input  logic                    field_start,
  input  logic [3:0]              group_sel,
  output logic                    ctrl_present,
  output logic [NUM_PARAMS*8-1:0] params_o
);
  logic                    flag_hit;
  logic                    commit;
  logic [7:0]              dc_q;
  logic [7:0]              want_id;
  logic [2:0]              grp_q;
  logic                    seen_q;
  logic [NUM_PARAMS*8-1:0] shadow;

  assign in_ready = 1'b1;

  acp_flag_detect u_flag (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word), .flag_hit(flag_hit)
  );

  acp_pkt_parser #(.NUM_PARAMS(NUM_PARAMS)) u_parse (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .flag_hit(flag_hit), .want_id(want_id), .commit(commit), .dc_q(dc_q),
    .shadow_o(shadow)
  );

  acp_param_bank #(.NUM_PARAMS(NUM_PARAMS)) u_bank (
    .clk(clk), .rst_n(rst_n), .load(commit), .shadow_i(shadow), .params_o(params_o)
  );

  acp_field_status u_stat (
    .clk(clk), .rst_n(rst_n), .field_start(field_start), .group_sel(group_sel),
    .commit(commit), .line_desig(line_desig), .grp_q(grp_q), .want_id(want_id),
    .seen_q(seen_q), .ctrl_present(ctrl_present)
  );
endmodule

// File: rtl/acp_capture_chk.sv
module acp_capture_chk #(
  parameter int NUM_PARAMS = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic [9:0]              in_word,
  input logic                    field_start,
  input logic                    line_desig,
  input logic                    commit,
  input logic                    seen_q,
  input logic [7:0]              dc_q,
  input logic [2:0]              grp_q,
  input logic                    ctrl_present,
  input logic [NUM_PARAMS*8-1:0] params_o
);
  a_r3_params_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(params_o));

  a_r4_count_floor: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (dc_q >= 8'(NUM_PARAMS)));

  a_r5_commit_clean_word: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (in_valid && in_word != 10'h000 && in_word != 10'h3FF));

  a_r6_group_range: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_q >= 3'd1) && (grp_q <= 3'd4));

  a_r7_only_at_field: assert property (@(posedge clk) disable iff (!rst_n)
    !field_start |=> $stable(ctrl_present));

  a_r7_needs_evidence: assert property (@(posedge clk) disable iff (!rst_n)
    (field_start && !seen_q && !(commit && line_desig)) |=> !ctrl_present);
endmodule

bind acp_capture acp_capture_chk #(.NUM_PARAMS(NUM_PARAMS)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
  .field_start(field_start), .line_desig(line_desig), .commit(commit),
  .seen_q(seen_q), .dc_q(dc_q), .grp_q(grp_q), .ctrl_present(ctrl_present),
  .params_o(params_o)
);

// File: tb/acp_capture_tb.sv
module acp_capture_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [9:0]  in_word = '0;
  logic        line_desig = 1'b0;
  logic        field_start = 1'b0;
  logic [3:0]  group_sel = 4'd1;
  logic        ctrl_present;
  logic [31:0] params_o;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  acp_capture u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .line_desig(line_desig), .field_start(field_start),
    .group_sel(group_sel), .ctrl_present(ctrl_present), .params_o(params_o)
  );

  typedef struct packed {
    logic [3:0] sel;
    logic [7:0] id;
    logic [7:0] dc;
    logic       desig;
    logic       trunc;
    logic       gap;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{4'd1, 8'hEF, 8'd4,  1'b1, 1'b0, 1'b0},
    '{4'd1, 8'hEF, 8'd6,  1'b0, 1'b0, 1'b1},
    '{4'd1, 8'hEE, 8'd4,  1'b1, 1'b0, 1'b0},
    '{4'd2, 8'hEE, 8'd4,  1'b1, 1'b0, 1'b1},
    '{4'd3, 8'hED, 8'd18, 1'b1, 1'b0, 1'b0},
    '{4'd4, 8'hEC, 8'd5,  1'b0, 1'b0, 1'b0},
    '{4'd4, 8'hEF, 8'd4,  1'b1, 1'b0, 1'b0},
    '{4'd4, 8'hEC, 8'd3,  1'b1, 1'b0, 1'b0},
    '{4'd4, 8'hEC, 8'd8,  1'b1, 1'b1, 1'b0},
    '{4'd0, 8'hEC, 8'd4,  1'b1, 1'b0, 1'b1},
    '{4'd9, 8'hEF, 8'd4,  1'b1, 1'b0, 1'b0},
    '{4'd1, 8'hEF, 8'd4,  1'b1, 1'b0, 1'b0}
  };

  function automatic logic [9:0] mk(input logic [7:0] b);
    logic p;
    p = ^b;
    return {~p, p, b};
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(input logic [9:0] w, input logic gap, input logic fs);
    if (gap) @(negedge clk);
    in_valid = 1'b1;
    in_word = w;
    field_start = fs;
    @(negedge clk);
    in_valid = 1'b0;
    field_start = 1'b0;
  endtask

  task automatic pulse_field();
    field_start = 1'b1;
    @(negedge clk);
    field_start = 1'b0;
  endtask

  task automatic send_pkt(input logic [7:0] id, input logic [7:0] dc, input logic [7:0] base,
                          input logic trunc, input logic gap, input logic fs_on_cs);
    put(10'h000, gap, 1'b0);
    put(10'h3FF, gap, 1'b0);
    put(10'h3FF, gap, 1'b0);
    put(mk(id), gap, 1'b0);
    put(mk(8'd1), gap, 1'b0);
    put(mk(dc), gap, 1'b0);
    for (int k = 0; k < int'(dc); k++) begin
      if (trunc && k == 2) begin
        put(10'h000, 1'b0, 1'b0);
        put(10'h3FF, 1'b0, 1'b0);
        put(10'h3FF, 1'b0, 1'b0);
        put(mk(8'h40), 1'b0, 1'b0);
        return;
      end
      put(mk(8'(base + 8'(k))), gap, 1'b0);
    end
    put(mk(8'h5A), gap, fs_on_cs);
  endtask

  function automatic logic [31:0] payload(input logic [7:0] base);
    return {8'(base + 8'd3), 8'(base + 8'd2), 8'(base + 8'd1), base};
  endfunction

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [2:0]  m_grp;
    logic [31:0] m_par;
    logic        match;
    logic [7:0]  base;

    repeat (3) @(negedge clk);
    // R10: outputs cleared by reset
    check(ctrl_present == 1'b0, "R10 present", ctrl_present, 0);
    check(params_o == 32'd0, "R10 params", params_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: ready held high
    check(in_ready == 1'b1, "R1 ready", in_ready, 1);

    // R6: group 1 active after reset, before any field_start
    group_sel = 4'd2;
    line_desig = 1'b1;
    send_pkt(8'hEF, 8'd4, 8'h10, 1'b0, 1'b0, 1'b0);
    check(params_o == payload(8'h10), "R6 default group", params_o, payload(8'h10));
    pulse_field();
    check(ctrl_present == 1'b1, "R6 default present", ctrl_present, 1);
    m_grp = 3'd2;
    m_par = payload(8'h10);

    // Table walk: one field per vector (R2 R3 R4 R5 R6 R7 R8 R9)
    for (int i = 0; i < NV; i++) begin
      group_sel = VEC[i].sel;
      pulse_field();
      if (VEC[i].sel >= 4'd1 && VEC[i].sel <= 4'd4) m_grp = VEC[i].sel[2:0];
      base = 8'(8'd32 + 8'(i * 16));
      line_desig = VEC[i].desig;
      send_pkt(VEC[i].id, VEC[i].dc, base, VEC[i].trunc, VEC[i].gap, 1'b0);
      match = (VEC[i].id == 8'(8'hF0 - {5'd0, m_grp})) && (VEC[i].dc >= 8'd4) && !VEC[i].trunc;
      if (match) m_par = payload(base);
      check(params_o == m_par, "R3 R4 R5 R9 params", params_o, m_par);
      pulse_field();
      check(ctrl_present == (match && VEC[i].desig), "R7 R8 present", ctrl_present,
            int'(match && VEC[i].desig));
    end

    // R7: checksum word in the same cycle as field_start
    group_sel = 4'd1;
    pulse_field();
    line_desig = 1'b1;
    send_pkt(8'hEF, 8'd4, 8'hA0, 1'b0, 1'b0, 1'b1);
    check(ctrl_present == 1'b1, "R7 same-cycle present", ctrl_present, 1);
    check(params_o == payload(8'hA0), "R3 same-cycle params", params_o, payload(8'hA0));
    repeat (3) @(negedge clk);
    check(ctrl_present == 1'b1, "R7 held between strobes", ctrl_present, 1);
    pulse_field();
    check(ctrl_present == 1'b0, "R7 empty field", ctrl_present, 0);

    finish_run();
  end
endmodule